// File: doc/BRIEF.md
# Two-Stage Decimating Low-Pass Filter

This block filters one real baseband channel and lowers its sample rate by 64 in two stages. The first stage is a fourth-order integrator-comb decimator. It has a sinx/x response, reduces the rate by 32 and has no multipliers. For a 4 MS/s input it delivers 125 kS/s. The second stage is a programmable symmetric FIR. It keeps one output for every two intermediate samples, which gives 62.5 kS/s, and it sets the passband edge, the transition band and the stopband floor.

The FIR evaluates one multiply-accumulate per tap on a single shared multiplier. It does this while it waits for the next intermediate sample. A small write port loads the unique half of the coefficient set, and the other half is mirrored from it. Each result is rounded and saturated to 24 bits, and a single-cycle valid strobe marks it.

The accepted input rate must leave at least 18 clock cycles between intermediate samples. Any rate of one sample per clock or slower meets this.

Top module: `cic_fir_decimator`

## Requirements
- R1: After reset, outValid is 0, outData is 0 and every coefficient slot holds 0, so the first results are 0 whatever the input.
- R2: The first stage applies ((1 - z^-32)/(1 - z^-1))^4 exactly to the accepted 16-bit two's complement samples. Its DC gain is 2^20 and its width is 36 bits. It produces an intermediate sample after every 32nd accepted input, counted from reset.
- R3: For each intermediate sample c_m, where m counts from 1 after reset, and only when m is even, the FIR forms y = sum over k = 0..15 of h_k * c_(m-k). Here h_k = slot[min(k, 15-k)] and history before reset counts as zero.
- R4: The result is floor((y + 2^30) / 2^31), which rounds halves toward plus infinity. It is then clamped to the range -8388608 to 8388607 and presented as 24-bit two's complement.
- R5: On a clock with coefWe high and coefAddr in 0..7, slot coefAddr takes coefData as a 20-bit two's complement value. A write with coefAddr in 8..15 changes no slot.
- R6: outValid is high for exactly one cycle per result, and there is one result per 64 accepted inputs. outData changes only in a cycle where outValid is high.
- R7: In a cycle with inValid low, inData is ignored and nothing advances, so gaps in the input stream do not change any result.
- R8: outValid is high after the 18th rising edge that follows the edge accepting the 64th input of a group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | inData carries a sample this cycle |
| inData | input | 16 | Input sample, two's complement |
| coefWe | input | 1 | Coefficient write strobe |
| coefAddr | input | 4 | Coefficient slot index; 8..15 ignored |
| coefData | input | 20 | Coefficient value, two's complement |
| outValid | output | 1 | One-cycle strobe marking a new result |
| outData | output | 24 | Rounded, saturated result |

## Verification
On every cycle the assertions check the control sequencing:
- dump strobes are never back to back;
- a history shift always follows a dump;
- a cleared accumulator is always followed by multiply-accumulate cycles;
- a load always raises a single-cycle valid;
- the output holds its value between strobes.

Only the bench can show the arithmetic. It drives impulses, constant levels, full-scale inputs and random streams with random gaps. It compares every result against an integer model of the cascaded moving sums and the mirrored tap sum, and it also checks the rounding ties, both saturation limits and ignored coefficient addresses.

// File: rtl/decim_pkg.sv
package decim_pkg;

  // Strobes issued by the sequencer to the datapath each cycle.
  typedef struct packed {
    logic integEn;    // accept one input sample into the integrators
    logic cicDump;    // take the decimated comb output
    logic histShift;  // push the new intermediate sample into the FIR history
    logic macClear;   // zero the accumulator before a new tap pass
    logic macEn;      // accumulate the product for the current tap
    logic outLoad;    // round, saturate and register the result
  } decim_strobe_t;

  typedef enum logic [1:0] {
    FIR_IDLE,
    FIR_MAC,
    FIR_FLUSH
  } fir_state_t;

endpackage

// File: rtl/decim_ctrl.sv
module decim_ctrl
  import decim_pkg::*;
#(
  parameter int CIC_R    = 32,
  parameter int FIR_R    = 2,
  parameter int FIR_TAPS = 16,
  localparam int PH_W    = $clog2(CIC_R),
  localparam int FR_W    = (FIR_R > 1) ? $clog2(FIR_R) : 1,
  localparam int TAP_W   = $clog2(FIR_TAPS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output decim_strobe_t    strb,
  output logic [TAP_W-1:0] tapIdx,
  output logic             outValid
);

  logic [PH_W-1:0]  phaseCnt;
  logic [FR_W-1:0]  firPhase;
  logic             cicValidQ;
  fir_state_t       state;
  logic [TAP_W-1:0] tapQ;
  logic             outValidQ;

  logic dumpNow;
  logic firFire;
  logic lastTap;

  assign dumpNow = inValid && (phaseCnt == PH_W'(CIC_R - 1));
  assign firFire = cicValidQ && (firPhase == FR_W'(FIR_R - 1));
  assign lastTap = (tapQ == TAP_W'(FIR_TAPS - 1));

  // Input phase: the dump strobe fires on every CIC_R-th accepted sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseCnt  <= '0;
      cicValidQ <= 1'b0;
    end else begin
      if (inValid) phaseCnt <= dumpNow ? '0 : phaseCnt + PH_W'(1);
      cicValidQ <= dumpNow;
    end
  end

  // Second-stage phase: a tap pass starts on every FIR_R-th intermediate sample.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firPhase <= '0;
    end else if (cicValidQ) begin
      firPhase <= firFire ? '0 : firPhase + FR_W'(1);
    end
  end

  // Tap sequencer: clear, one multiply-accumulate per tap, then flush.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= FIR_IDLE;
      tapQ      <= '0;
      outValidQ <= 1'b0;
    end else begin
      outValidQ <= (state == FIR_FLUSH);
      case (state)
        FIR_IDLE: begin
          if (firFire) begin
            state <= FIR_MAC;
            tapQ  <= '0;
          end
        end
        FIR_MAC: begin
          tapQ <= tapQ + TAP_W'(1);
          if (lastTap) state <= FIR_FLUSH;
        end
        FIR_FLUSH: state <= FIR_IDLE;
        default:   state <= FIR_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.integEn   = inValid;
    strb.cicDump   = dumpNow;
    strb.histShift = cicValidQ;
    strb.macClear  = firFire;
    strb.macEn     = (state == FIR_MAC);
    strb.outLoad   = (state == FIR_FLUSH);
  end

  assign tapIdx   = tapQ;
  assign outValid = outValidQ;

endmodule

// File: rtl/decim_datapath.sv
module decim_datapath
  import decim_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int COEF_W    = 20,
  parameter int OUT_W     = 24,
  parameter int CIC_N     = 4,
  parameter int CIC_R     = 32,
  parameter int FIR_TAPS  = 16,
  parameter int OUT_SHIFT = 31,
  localparam int CIC_GROW = CIC_N * $clog2(CIC_R),
  localparam int CIC_W    = IN_W + CIC_GROW,
  localparam int TAP_W    = $clog2(FIR_TAPS),
  localparam int HALF     = (FIR_TAPS + 1) / 2,
  localparam int HIDX_W   = (HALF > 1) ? $clog2(HALF) : 1,
  localparam int PROD_W   = CIC_W + COEF_W,
  localparam int ACC_W    = PROD_W + TAP_W,
  localparam int RND_W    = ACC_W + 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  decim_strobe_t            strb,
  input  logic [TAP_W-1:0]         tapIdx,
  input  logic signed [IN_W-1:0]   inData,
  input  logic                     coefWe,
  input  logic [TAP_W-1:0]         coefAddr,
  input  logic signed [COEF_W-1:0] coefData,
  output logic signed [OUT_W-1:0]  outData
);

  localparam logic signed [RND_W-1:0] RND_HALF = RND_W'(1) <<< (OUT_SHIFT - 1);
  localparam logic signed [RND_W-1:0] SAT_HI   = (RND_W'(1) <<< (OUT_W - 1)) - RND_W'(1);
  localparam logic signed [RND_W-1:0] SAT_LO   = -SAT_HI - RND_W'(1);

  // ---------------- integrator-comb stage ----------------
  logic signed [CIC_W-1:0] integQ     [CIC_N];
  logic signed [CIC_W-1:0] integChain [CIC_N+1];
  logic signed [CIC_W-1:0] combDly    [CIC_N];
  logic signed [CIC_W-1:0] combChain  [CIC_N+1];
  logic signed [CIC_W-1:0] cicOut;

  assign integChain[0] = {{CIC_GROW{inData[IN_W-1]}}, inData};

  for (genvar g = 0; g < CIC_N; g++) begin : g_integ
    // Unpipelined chain: each section sees this sample's sum from the one before.
    assign integChain[g+1] = integQ[g] + integChain[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             integQ[g] <= '0;
      else if (strb.integEn) integQ[g] <= integChain[g+1];
    end
  end

  assign combChain[0] = integChain[CIC_N];

  for (genvar g = 0; g < CIC_N; g++) begin : g_comb
    // Differences at the reduced rate; wraparound cancels the integrator overflow.
    assign combChain[g+1] = combChain[g] - combDly[g];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             combDly[g] <= '0;
      else if (strb.cicDump) combDly[g] <= combChain[g];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cicOut <= '0;
    else if (strb.cicDump) cicOut <= combChain[CIC_N];
  end

  // ---------------- FIR history and coefficients ----------------
  logic signed [CIC_W-1:0]  hist    [FIR_TAPS];
  logic signed [COEF_W-1:0] coefMem [HALF];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < FIR_TAPS; k++) hist[k] <= '0;
    end else if (strb.histShift) begin
      hist[0] <= cicOut;
      for (int k = 1; k < FIR_TAPS; k++) hist[k] <= hist[k-1];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int k = 0; k < HALF; k++) coefMem[k] <= '0;
    end else if (coefWe && (coefAddr < TAP_W'(HALF))) begin
      coefMem[coefAddr[HIDX_W-1:0]] <= coefData;
    end
  end

  // ---------------- multiply-accumulate ----------------
  logic [HIDX_W-1:0]        mirIdx;
  logic signed [COEF_W-1:0] coefSel;
  logic signed [CIC_W-1:0]  histSel;
  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  accQ;

  // Taps past the centre reuse the slot of their mirror partner.
  assign mirIdx  = (tapIdx < TAP_W'(HALF)) ? tapIdx[HIDX_W-1:0]
                                           : HIDX_W'(TAP_W'(FIR_TAPS - 1) - tapIdx);
  assign coefSel = coefMem[mirIdx];
  assign histSel = hist[tapIdx];
  assign prod    = coefSel * histSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              accQ <= '0;
    else if (strb.macClear) accQ <= '0;
    else if (strb.macEn)    accQ <= accQ + {{TAP_W{prod[PROD_W-1]}}, prod};
  end

  // ---------------- round and saturate ----------------
  logic signed [RND_W-1:0] accExt;
  logic signed [RND_W-1:0] roundSum;
  logic signed [RND_W-1:0] scaled;
  logic signed [OUT_W-1:0] satVal;

  assign accExt   = {accQ[ACC_W-1], accQ};
  assign roundSum = accExt + RND_HALF;
  assign scaled   = roundSum >>> OUT_SHIFT;

  always_comb begin
    if (scaled > SAT_HI)      satVal = SAT_HI[OUT_W-1:0];
    else if (scaled < SAT_LO) satVal = SAT_LO[OUT_W-1:0];
    else                      satVal = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outData <= '0;
    else if (strb.outLoad) outData <= satVal;
  end

endmodule

// File: rtl/cic_fir_decimator.sv
module cic_fir_decimator
  import decim_pkg::*;
#(
  parameter int IN_W      = 16,
  parameter int COEF_W    = 20,
  parameter int OUT_W     = 24,
  parameter int CIC_N     = 4,
  parameter int CIC_R     = 32,
  parameter int FIR_R     = 2,
  parameter int FIR_TAPS  = 16,
  parameter int OUT_SHIFT = 31
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         inValid,
  input  logic [IN_W-1:0]              inData,
  input  logic                         coefWe,
  input  logic [$clog2(FIR_TAPS)-1:0]  coefAddr,
  input  logic [COEF_W-1:0]            coefData,
  output logic                         outValid,
  output logic [OUT_W-1:0]             outData
);

  localparam int TAP_W = $clog2(FIR_TAPS);

  decim_strobe_t    strb;
  logic [TAP_W-1:0] tapIdx;

  decim_ctrl #(
    .CIC_R    (CIC_R),
    .FIR_R    (FIR_R),
    .FIR_TAPS (FIR_TAPS)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .strb     (strb),
    .tapIdx   (tapIdx),
    .outValid (outValid)
  );

  decim_datapath #(
    .IN_W      (IN_W),
    .COEF_W    (COEF_W),
    .OUT_W     (OUT_W),
    .CIC_N     (CIC_N),
    .CIC_R     (CIC_R),
    .FIR_TAPS  (FIR_TAPS),
    .OUT_SHIFT (OUT_SHIFT)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .tapIdx   (tapIdx),
    .inData   (inData),
    .coefWe   (coefWe),
    .coefAddr (coefAddr),
    .coefData (coefData),
    .outData  (outData)
  );

endmodule

// File: rtl/decim_checker.sv
module decim_checker
  import decim_pkg::*;
#(
  parameter int OUT_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             outValid,
  input logic [OUT_W-1:0] outData,
  input decim_strobe_t    strb
);

  // R2: a dump marks the 32nd sample of a group, so two never arrive back to back
  a_r2_dump_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strb.cicDump |=> !strb.cicDump);

  // R3: the history only moves on the cycle after a dump
  a_r3_shift_after_dump: assert property (@(posedge clk) disable iff (!rstN)
    strb.histShift |-> $past(strb.cicDump));

  // R3: a cleared accumulator is always followed by tap accumulation
  a_r3_clear_then_mac: assert property (@(posedge clk) disable iff (!rstN)
    strb.macClear |=> strb.macEn);

  // R6: loading the output register raises the valid strobe
  a_r6_load_marks_valid: assert property (@(posedge clk) disable iff (!rstN)
    strb.outLoad |=> outValid);

  // R6: the valid strobe lasts one cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid |=> !outValid);

  // R6: the result holds between strobes
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outData) |-> outValid);

endmodule

bind cic_fir_decimator decim_checker #(.OUT_W(OUT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .outValid (outValid),
  .outData  (outData),
  .strb     (strb)
);

// File: tb/cic_fir_decimator_tb.sv
`timescale 1ns/1ps
module cic_fir_decimator_tb;

  localparam int TAPS = 16;
  localparam int HALF = 8;
  localparam int GRP  = 64;

  logic               clk = 1'b0;
  logic               rstN = 1'b0;
  logic               inValid = 1'b0;
  logic signed [15:0] inData = '0;
  logic               coefWe = 1'b0;
  logic [3:0]         coefAddr = '0;
  logic [19:0]        coefData = '0;
  logic               outValid;
  logic [23:0]        outData;

  int  checks = 0;
  int  failures = 0;
  int  cyc = 0;
  bit  done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  cic_fir_decimator u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .coefWe(coefWe), .coefAddr(coefAddr), .coefData(coefData),
    .outValid(outValid), .outData(outData)
  );

  // Model state: four moving sums of length 32, then the mirrored tap sum.
  longint stgBuf [4][32];
  longint runSum [4];
  longint firHist [TAPS];
  longint coefM [HALF];
  longint expQ [$];
  int     latQ [$];
  int     ptr, nAcc, cicCnt, nOut;
  longint lastOut;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint roundSat(longint y);
    longint r;
    r = (y + (longint'(1) <<< 30)) >>> 31;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  task automatic modelStep(longint x);
    longint v, old, y;
    v = x;
    for (int s = 0; s < 4; s++) begin
      old = stgBuf[s][ptr];
      stgBuf[s][ptr] = v;
      runSum[s] = runSum[s] + v - old;
      v = runSum[s];
    end
    ptr = (ptr + 1) % 32;
    nAcc++;
    if (nAcc % 32 == 0) begin
      for (int k = TAPS - 1; k > 0; k--) firHist[k] = firHist[k-1];
      firHist[0] = v;
      cicCnt++;
      if (cicCnt % 2 == 0) begin
        y = 0;
        for (int k = 0; k < TAPS; k++)
          y += coefM[(k < HALF) ? k : (TAPS - 1 - k)] * firHist[k];
        expQ.push_back(roundSat(y));
        latQ.push_back(cyc);
      end
    end
  endtask

  task automatic clearModel();
    for (int s = 0; s < 4; s++) begin
      runSum[s] = 0;
      for (int j = 0; j < 32; j++) stgBuf[s][j] = 0;
    end
    for (int k = 0; k < TAPS; k++) firHist[k] = 0;
    for (int k = 0; k < HALF; k++) coefM[k] = 0;
    expQ.delete();
    latQ.delete();
    ptr = 0; nAcc = 0; cicCnt = 0; nOut = 0; lastOut = 0;
  endtask

  // Every result is compared with the model (R3, R4) and its latency checked (R8).
  always @(negedge clk) begin
    if (rstN && outValid) begin
      nOut++;
      lastOut = longint'($signed(outData));
      if (expQ.size() == 0) begin
        checks++;
        failures++;
        $display("FAIL R6 unexpected result actual=%0d expected=none", lastOut);
      end else begin
        check("R3 R4 result vs model", lastOut, expQ.pop_front());
        check("R8 latency", longint'(cyc - latQ.pop_front()), 19);
      end
    end
  end

  task automatic pushIn(longint x, bit v);
    @(negedge clk);
    inValid = v;
    inData  = 16'(x);
    if (v) modelStep(x);
  endtask

  task automatic settle(int n);
    @(negedge clk);
    inValid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic writeCoef(int a, longint d);
    @(negedge clk);
    inValid  = 1'b0;
    coefWe   = 1'b1;
    coefAddr = 4'(a);
    coefData = 20'(d);
    if (a < HALF) coefM[a] = longint'($signed(20'(d)));
    @(negedge clk);
    coefWe = 1'b0;
  endtask

  task automatic doReset();
    settle(40);
    check("R6 all expected results delivered", longint'(expQ.size()), 0);
    rstN = 1'b0;
    clearModel();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic runConst(longint x, int n);
    repeat (n) pushIn(x, 1'b1);
  endtask

  initial begin
    clearModel();
    repeat (3) @(negedge clk);
    check("R1 outValid in reset", longint'(outValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 outValid after reset", longint'(outValid), 0);
    check("R1 outData after reset", longint'($signed(outData)), 0);

    // R1: slots reset to zero, so full-scale input still yields zero
    runConst(32767, 4 * GRP);
    settle(25);
    check("R1 zero slots give zero", lastOut, 0);
    check("R6 one result per 64 inputs", longint'(nOut), 4);

    // R2 R3 R5: impulses through a mixed-sign set; writes to 8..15 ignored
    doReset();
    writeCoef(0, -1200);  writeCoef(1, 3500);   writeCoef(2, 9000);
    writeCoef(3, -20000); writeCoef(4, 60000);  writeCoef(5, 150000);
    writeCoef(6, 300000); writeCoef(7, 480000);
    writeCoef(9, 524287); writeCoef(15, -524288); writeCoef(8, 77777);
    pushIn(30000, 1'b1);
    runConst(0, 6 * GRP - 1);
    pushIn(-32768, 1'b1);
    runConst(0, 6 * GRP - 1);
    settle(25);
    check("R6 result count after impulses", longint'(nOut), 12);
    check("R5 ignored addresses leave response intact", longint'(expQ.size()), 0);

    // R2 R4: DC gain 2^20 with taps summing to 2^19 gives input * 256
    doReset();
    for (int a = 0; a < HALF; a++) writeCoef(a, 32768);
    runConst(16384, 16 * GRP);
    settle(25);
    check("R2 R4 steady DC level", lastOut, 4194304);

    // R4: saturation at both limits
    doReset();
    for (int a = 0; a < HALF; a++) writeCoef(a, 524287);
    runConst(32767, 16 * GRP);
    settle(25);
    check("R4 positive saturation", lastOut, 8388607);
    runConst(-32768, 16 * GRP);
    settle(25);
    check("R4 negative saturation", lastOut, -8388608);

    // R4: rounding ties go toward plus infinity
    doReset(); writeCoef(0, 1); runConst(512, 16 * GRP);  settle(25);
    check("R4 +0.5 rounds to 1", lastOut, 1);
    doReset(); writeCoef(0, 1); runConst(-512, 16 * GRP); settle(25);
    check("R4 -0.5 rounds to 0", lastOut, 0);
    doReset(); writeCoef(0, 1); runConst(511, 16 * GRP);  settle(25);
    check("R4 below half rounds to 0", lastOut, 0);
    doReset(); writeCoef(0, 1); runConst(-513, 16 * GRP); settle(25);
    check("R4 below -half rounds to -1", lastOut, -1);

    // R7 R6: random data and coefficients with random idle gaps
    doReset();
    for (int a = 0; a < HALF; a++) writeCoef(a, longint'($signed(20'($urandom))));
    for (int a = HALF; a < TAPS; a++) writeCoef(a, longint'($urandom_range(0, 1048575)));
    for (int i = 0; i < 6400; i++) begin
      bit v;
      v = ($urandom_range(0, 2) != 0);
      pushIn(longint'($signed(16'($urandom))), v);
    end
    settle(25);
    check("R7 R6 result count with gaps", longint'(nOut), longint'(nAcc / GRP));

    doReset();
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL R6 watchdog actual=timeout expected=completion");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule